// File: doc/BRIEF.md
# Circuit-Switched Path Reservation Router Node

This block is one router of a two-dimensional mesh that moves messages over dedicated circuits. A sender first emits a short setup word that carries the destination coordinates. At each node that setup word claims one output channel, chosen by dimension order. When the claim succeeds, that input and that output are joined for the life of the message. Every later word of the message then crosses the node through plain wiring, with no storage.

When the wanted output already belongs to another circuit, the node consumes the setup word. It then sends a release pulse back toward the sender, so that upstream nodes drop the half-built path. A circuit is freed in one of two ways. The first is when the closing word of the message crosses the node in the forward direction. The second is when a release pulse comes back from downstream through the output. In the second case the pulse is passed on upstream through the input that owned the circuit.

Each of the five ports (local, east, west, north, south) has a forward input and a forward output with a valid/ready handshake, plus a one-bit reverse pulse in each direction. The node's own coordinates are parameters.

Top module: `cs_circuit_node`

## Requirements
- R1: After reset no output is valid, no reverse pulse is sent, and no circuit exists.
- R2: Port numbers are 0 local, 1 east, 2 west, 3 north, 4 south. A setup word (type 00) holds the destination X in payload bits [7:4] and Y in bits [3:0]. If X is greater than the node's X it goes east, and if smaller it goes west. When X matches, a greater Y goes north and a smaller Y goes south. When both match, the word goes to the local output.
- R3: A setup word on an unconnected input whose chosen output is free is granted. In the grant cycle its in_rdy stays low. From the next cycle the chosen output presents that same word.
- R4: While an input is joined to an output, that output's valid, type and payload equal the input's in the same cycle, and the input's in_rdy equals that output's out_rdy.
- R5: A setup word whose chosen output is already owned is consumed in that cycle, with in_rdy high. One cycle later a single release pulse appears on rev_out_vld of that input. The existing circuit on that output is left unchanged.
- R6: When several setup words request the same free output in one cycle, exactly one is granted. The others are handled as in R5. Priority rotates: the first requester at or after a per-output pointer wins, and the pointer then moves to the index just after the winner.
- R7: A transfer of a closing word (type 10) through a circuit frees both the input and the output from the next cycle.
- R8: A pulse on rev_in_vld of an owned output frees that circuit and gives a pulse on rev_out_vld of the owning input one cycle later. The same pulse on a free output has no effect.
- R9: A word of any type other than 00 on an unconnected input is consumed, with in_rdy high, and is not forwarded to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 5 | Forward word valid, one bit per input port |
| in_typ | input | 10 | Word type, 2 bits per port (00 setup, 01 data, 10 closing, 11 release) |
| in_pay | input | 80 | Payload, 16 bits per port |
| in_rdy | output | 5 | Input word accepted |
| out_vld | output | 5 | Forward word valid, one bit per output port |
| out_typ | output | 10 | Forwarded word type, 2 bits per port |
| out_pay | output | 80 | Forwarded payload, 16 bits per port |
| out_rdy | input | 5 | Downstream ready per output port |
| rev_in_vld | input | 5 | Release/acknowledge pulse arriving from downstream of each output |
| rev_out_vld | output | 5 | Release/acknowledge pulse sent upstream on each input |

## Verification
The hardest situation to reach from the ports is a same-cycle contest in which the rotating pointer decides the winner. The pointer depends on every earlier grant to that output, so the stimulus must make two inputs present setup words for one free output in the same cycle, more than once in a row. The bench does this with directed rounds between the local and west inputs aimed east. Between rounds it frees the circuit with a reverse pulse, and a bench model of each pointer predicts the winner. A blocked setup word against a live circuit is also set up on purpose, and random single-circuit traffic then covers all routes and both ways of freeing a circuit.

// File: rtl/cs_node_pkg.sv
package cs_node_pkg;

  localparam int NPORT   = 5;
  localparam int PIDX_W  = 3;

  typedef enum logic [1:0] {
    W_SETUP = 2'b00,
    W_DATA  = 2'b01,
    W_CLOSE = 2'b10,
    W_REL   = 2'b11
  } wtype_e;

  localparam logic [PIDX_W-1:0] P_LOCAL = 3'd0;
  localparam logic [PIDX_W-1:0] P_EAST  = 3'd1;
  localparam logic [PIDX_W-1:0] P_WEST  = 3'd2;
  localparam logic [PIDX_W-1:0] P_NORTH = 3'd3;
  localparam logic [PIDX_W-1:0] P_SOUTH = 3'd4;

  typedef struct packed {
    logic              vld;
    logic [PIDX_W-1:0] idx;
  } link_t;

endpackage

// File: rtl/cs_route.sv
module cs_route
  import cs_node_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int PAY_W   = 16,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic [PAY_W-1:0]  pay,
  output logic [PIDX_W-1:0] port
);
  localparam logic [COORD_W-1:0] MX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] MY = COORD_W'(MY_Y);

  logic [COORD_W-1:0] dx, dy;

  assign dx = pay[2*COORD_W-1:COORD_W];
  assign dy = pay[COORD_W-1:0];

  always_comb begin
    if (dx > MX)      port = P_EAST;
    else if (dx < MX) port = P_WEST;
    else if (dy > MY) port = P_NORTH;
    else if (dy < MY) port = P_SOUTH;
    else              port = P_LOCAL;
  end
endmodule

// File: rtl/cs_rr_arb.sv
module cs_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic          found;

  always_comb begin
    gnt   = '0;
    ptr_d = ptr_q;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int s;
      s = int'(ptr_q) + off;
      if (s >= N) s = s - N;
      if (!found && req[s]) begin
        gnt[s] = 1'b1;
        found  = 1'b1;
        ptr_d  = (s == N-1) ? '0 : IW'(s + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (|req)  ptr_q <= ptr_d;
  end

  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R6
  gnt_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((|gnt) && ((gnt & ~req) == '0)));
endmodule

// File: rtl/cs_circuit_node.sv
module cs_circuit_node
  import cs_node_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int PAY_W   = 16,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       in_vld,
  input  logic [2*NPORT-1:0]     in_typ,
  input  logic [PAY_W*NPORT-1:0] in_pay,
  output logic [NPORT-1:0]       in_rdy,
  output logic [NPORT-1:0]       out_vld,
  output logic [2*NPORT-1:0]     out_typ,
  output logic [PAY_W*NPORT-1:0] out_pay,
  input  logic [NPORT-1:0]       out_rdy,
  input  logic [NPORT-1:0]       rev_in_vld,
  output logic [NPORT-1:0]       rev_out_vld
);
  localparam int NP = NPORT;

  logic [1:0]        typ_i [NP];
  logic [PAY_W-1:0]  pay_i [NP];
  logic [PIDX_W-1:0] dst   [NP];

  link_t own_q  [NP];
  link_t own_d  [NP];
  link_t conn_q [NP];
  link_t conn_d [NP];

  logic [NP-1:0] rev_q, rev_d;
  logic [NP-1:0] setup_req, granted, blocked, fwd_fire, close_rel, rev_hit;
  logic [NP-1:0] arb_req [NP];
  logic [NP-1:0] gnt     [NP];
  logic          upd;

  // per-input decode and routing
  for (genvar i = 0; i < NP; i++) begin : g_in
    assign typ_i[i] = in_typ[2*i +: 2];
    assign pay_i[i] = in_pay[PAY_W*i +: PAY_W];

    cs_route #(.COORD_W(COORD_W), .PAY_W(PAY_W), .MY_X(MY_X), .MY_Y(MY_Y)) i_route (
      .pay  (pay_i[i]),
      .port (dst[i])
    );

    assign setup_req[i] = in_vld[i] && !conn_q[i].vld && (typ_i[i] == W_SETUP);
  end

  // per-output arbitration among setup requests for a free output
  for (genvar o = 0; o < NP; o++) begin : g_out
    for (genvar i = 0; i < NP; i++) begin : g_req
      assign arb_req[o][i] = setup_req[i] && (dst[i] == PIDX_W'(o)) && !own_q[o].vld;
    end

    cs_rr_arb #(.N(NP)) i_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_req[o]),
      .gnt   (gnt[o])
    );

    assign rev_hit[o] = rev_in_vld[o] && own_q[o].vld;
  end

  // grant collection, forward handshakes and input ready
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      granted[i]  = 1'b0;
      fwd_fire[i] = 1'b0;
      in_rdy[i]   = 1'b0;
      for (int o = 0; o < NP; o++) begin
        if (gnt[o][i]) granted[i] = 1'b1;
        if (conn_q[i].vld && (conn_q[i].idx == PIDX_W'(o))) in_rdy[i] = out_rdy[o];
      end
      blocked[i]   = setup_req[i] && !granted[i];
      fwd_fire[i]  = conn_q[i].vld && in_vld[i] && in_rdy[i];
      close_rel[i] = fwd_fire[i] && (typ_i[i] == W_CLOSE);
      if (!conn_q[i].vld)
        in_rdy[i] = blocked[i] || (in_vld[i] && (typ_i[i] != W_SETUP));
    end
  end

  // crossbar: output driven by its owning input, no storage
  always_comb begin
    out_vld = '0;
    out_typ = '0;
    out_pay = '0;
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (own_q[o].vld && (own_q[o].idx == PIDX_W'(i))) begin
          out_vld[o]               = in_vld[i];
          out_typ[2*o +: 2]        = typ_i[i];
          out_pay[PAY_W*o +: PAY_W] = pay_i[i];
        end
      end
    end
  end

  // next state of reservations and reverse pulses
  always_comb begin
    for (int k = 0; k < NP; k++) begin
      own_d[k]  = own_q[k];
      conn_d[k] = conn_q[k];
    end
    rev_d = blocked;
    for (int i = 0; i < NP; i++) begin
      if (close_rel[i]) begin
        conn_d[i].vld = 1'b0;
        for (int o = 0; o < NP; o++)
          if (conn_q[i].idx == PIDX_W'(o)) own_d[o].vld = 1'b0;
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (rev_hit[o]) begin
        own_d[o].vld = 1'b0;
        for (int i = 0; i < NP; i++) begin
          if (own_q[o].idx == PIDX_W'(i)) begin
            conn_d[i].vld = 1'b0;
            rev_d[i]      = 1'b1;
          end
        end
      end
    end
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (gnt[o][i]) begin
          own_d[o]  = '{vld: 1'b1, idx: PIDX_W'(i)};
          conn_d[i] = '{vld: 1'b1, idx: PIDX_W'(o)};
        end
      end
    end
  end

  assign upd = (|close_rel) || (|rev_hit) || (|granted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) begin
        own_q[k]  <= '0;
        conn_q[k] <= '0;
      end
    end else if (upd) begin
      for (int k = 0; k < NP; k++) begin
        own_q[k]  <= own_d[k];
        conn_q[k] <= conn_d[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rev_q <= '0;
    else        rev_q <= rev_d;
  end

  assign rev_out_vld = rev_q;

  // assertions
  for (genvar o = 0; o < NP; o++) begin : g_chk_o
    // R8
    rev_frees_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_in_vld[o] && own_q[o].vld) |=> !own_q[o].vld);

    for (genvar i = 0; i < NP; i++) begin : g_chk_oi
      // R5
      owner_matches_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q[o].vld && (own_q[o].idx == PIDX_W'(i))) |->
          (conn_q[i].vld && (conn_q[i].idx == PIDX_W'(o))));

      // R3
      grant_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[o][i] |=> (own_q[o].vld && (own_q[o].idx == PIDX_W'(i))));

      // R4
      passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_q[i].vld && (conn_q[i].idx == PIDX_W'(o)) && in_vld[i]) |->
          (out_vld[o] && (out_pay[PAY_W*o +: PAY_W] == pay_i[i])));
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk_i
    // R7
    close_frees_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_rel[i] |=> !conn_q[i].vld);

    // R5
    blocked_teardown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[i] |=> rev_out_vld[i]);
  end
endmodule

// File: tb/test_cs_circuit_node.sv
module test_cs_circuit_node;
  localparam int NP = 5;
  localparam int PW = 16;
  localparam int MX = 2;
  localparam int MY = 2;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   in_vld;
  logic [2*NP-1:0] in_typ;
  logic [PW*NP-1:0] in_pay;
  logic [NP-1:0]   in_rdy;
  logic [NP-1:0]   out_vld;
  logic [2*NP-1:0] out_typ;
  logic [PW*NP-1:0] out_pay;
  logic [NP-1:0]   out_rdy;
  logic [NP-1:0]   rev_in_vld;
  logic [NP-1:0]   rev_out_vld;

  int checks;
  int errors;
  int ptr_m [NP];

  cs_circuit_node #(.COORD_W(4), .PAY_W(PW), .MY_X(MX), .MY_Y(MY)) i_cs_circuit_node (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_typ(in_typ), .in_pay(in_pay), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_typ(out_typ), .out_pay(out_pay), .out_rdy(out_rdy),
    .rev_in_vld(rev_in_vld), .rev_out_vld(rev_out_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_route(input logic [15:0] p);
    int x, y;
    x = int'(p[7:4]);
    y = int'(p[3:0]);
    if (x > MX) return 1;
    if (x < MX) return 2;
    if (y > MY) return 3;
    if (y < MY) return 4;
    return 0;
  endfunction

  function automatic int exp_winner(input int ptr, input logic [NP-1:0] mask);
    for (int off = 0; off < NP; off++) begin
      int s;
      s = (ptr + off) % NP;
      if (mask[s]) return s;
    end
    return -1;
  endfunction

  function automatic logic [15:0] setup_pay(input int x, input int y);
    return {8'h00, 4'(x), 4'(y)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int p, input logic [1:0] t, input logic [15:0] d);
    in_vld[p]         = 1'b1;
    in_typ[2*p +: 2]  = t;
    in_pay[PW*p +: PW] = d;
  endtask

  task automatic drop(input int p);
    in_vld[p] = 1'b0;
  endtask

  // establish a circuit from input i; returns chosen output
  task automatic open_path(input int i, input logic [15:0] sp, output int o, input string tag);
    o = exp_route(sp);
    put(i, 2'b00, sp);
    #1;
    chk(in_rdy[i] == 1'b0, "R3", in_rdy[i], 0);
    tick();
    ptr_m[o] = (i + 1) % NP;
    #1;
    chk(out_vld[o] && out_typ[2*o +: 2] == 2'b00 && out_pay[PW*o +: PW] == sp,
        tag, out_pay[PW*o +: PW], sp);
    tick(); // setup word passes, out_rdy high
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int o, o2, w, l;
    logic [15:0] d;
    checks = 0;
    errors = 0;
    for (int k = 0; k < NP; k++) ptr_m[k] = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_vld = '0; in_typ = '0; in_pay = '0;
    out_rdy = '1; rev_in_vld = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1
    chk(out_vld == '0, "R1", out_vld, 0);
    chk(rev_out_vld == '0, "R1", rev_out_vld, 0);

    // R2 local delivery then closing word
    open_path(0, setup_pay(MX, MY), o, "R2");
    chk(o == 0, "R2", o, 0);
    put(0, 2'b10, 16'h0000);
    tick();
    drop(0);
    #1;
    chk(out_vld[0] == 1'b0, "R7", out_vld[0], 0);

    // west input to east output; data and backpressure
    open_path(2, setup_pay(7, 2), o, "R3");
    put(2, 2'b01, 16'hA5C3);
    #1;
    chk(out_vld[1] && out_pay[PW*1 +: PW] == 16'hA5C3, "R4", out_pay[PW*1 +: PW], 16'hA5C3);
    out_rdy[1] = 1'b0;
    #1;
    chk(in_rdy[2] == 1'b0, "R4", in_rdy[2], 0);
    out_rdy[1] = 1'b1;

    // R5 contender from local while east held
    put(0, 2'b00, setup_pay(9, 0));
    #1;
    chk(in_rdy[0] == 1'b1, "R5", in_rdy[0], 1);
    tick();
    drop(0);
    #1;
    chk(rev_out_vld[0] == 1'b1, "R5", rev_out_vld[0], 1);
    chk(out_vld[1] && out_pay[PW*1 +: PW] == 16'hA5C3, "R5", out_pay[PW*1 +: PW], 16'hA5C3);
    tick();
    chk(rev_out_vld[0] == 1'b0, "R5", rev_out_vld[0], 0);

    // R8 pulse on a free output is ignored
    rev_in_vld[3] = 1'b1;
    tick();
    rev_in_vld[3] = 1'b0;
    #1;
    chk(rev_out_vld == '0, "R8", rev_out_vld, 0);
    chk(out_vld[1] == 1'b1, "R8", out_vld[1], 1);

    // R9 stray data word on unconnected north input
    put(3, 2'b01, 16'h1234);
    #1;
    chk(in_rdy[3] == 1'b1, "R9", in_rdy[3], 1);
    chk(out_vld == 5'b00010, "R9", out_vld, 5'b00010);
    tick();
    drop(3);

    // R7 closing word frees east
    put(2, 2'b10, 16'h0000);
    tick();
    drop(2);
    #1;
    chk(out_vld[1] == 1'b0, "R7", out_vld[1], 0);

    // R6 rotating contest between inputs 0 and 2 for east
    for (int r = 0; r < 3; r++) begin
      w = exp_winner(ptr_m[1], 5'b00101);
      l = (w == 0) ? 2 : 0;
      put(0, 2'b00, setup_pay(9, r));
      put(2, 2'b00, setup_pay(9, r));
      #1;
      chk(in_rdy[w] == 1'b0 && in_rdy[l] == 1'b1, "R6", in_rdy, w);
      tick();
      ptr_m[1] = (w + 1) % NP;
      drop(l);
      #1;
      chk(rev_out_vld[l] == 1'b1 && rev_out_vld[w] == 1'b0, "R6", rev_out_vld, l);
      chk(out_vld[1] == 1'b1, "R6", out_vld[1], 1);
      tick();
      drop(w);
      rev_in_vld[1] = 1'b1;
      tick();
      rev_in_vld[1] = 1'b0;
      #1;
      chk(rev_out_vld[w] == 1'b1, "R8", rev_out_vld, w);
      chk(out_vld[1] == 1'b0, "R8", out_vld[1], 0);
      tick();
    end

    // random single circuits
    for (int it = 0; it < 150; it++) begin
      int i, n;
      i = int'($urandom_range(0, NP-1));
      open_path(i, setup_pay(int'($urandom_range(0, 15)), int'($urandom_range(0, 15))), o2, "R2");
      n = int'($urandom_range(1, 4));
      for (int k = 0; k < n; k++) begin
        d = 16'($urandom);
        put(i, 2'b01, d);
        out_rdy[o2] = ($urandom_range(0, 3) != 0);
        #1;
        chk(out_vld[o2] && out_pay[PW*o2 +: PW] == d, "R4", out_pay[PW*o2 +: PW], d);
        chk(in_rdy[i] == out_rdy[o2], "R4", in_rdy[i], out_rdy[o2]);
        tick();
        out_rdy = '1;
      end
      if ($urandom_range(0, 1) == 0) begin
        put(i, 2'b10, 16'h0000);
        tick();
        drop(i);
        #1;
        chk(out_vld[o2] == 1'b0, "R7", out_vld[o2], 0);
      end else begin
        drop(i);
        rev_in_vld[o2] = 1'b1;
        tick();
        rev_in_vld[o2] = 1'b0;
        #1;
        chk(rev_out_vld[i] == 1'b1, "R8", rev_out_vld, i);
      end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule